// File: doc/BRIEF.md
# Windowed Keyed Watchdog

This block is a computer-operating-properly watchdog. A 3-bit rate select picks the timeout period, and a rate select of zero switches the watchdog off. Software keeps the system alive by writing a two-byte key to a write-only service register over a simple write strobe with an 8-bit data bus. The first key byte is 0x55 and the second is 0xAA. If the key is not completed in time, or if a bad value or a badly timed write reaches the register, the block raises a one-cycle reset request.

With the window-enable input set, the service register may only be written in the final quarter of the period. A write that arrives earlier counts as a fault, even when it carries a valid key byte. The block provides no other software access. Reading the service register always returns zero.

Top module: `keyed_window_wdog`

## Requirements
- R1: `rd_data` is 0x00 at all times, including during reset.
- R2: While `rate_sel` is 0 the watchdog is idle. Writes of any value do not raise `rst_req`, and no timeout occurs however long the wait.
- R3: For a nonzero `rate_sel` n, the period is P = 2^(BASE_LOG2 + STEP_LOG2·n) cycles. If the key is not completed, `rst_req` is seen high P cycles after counting starts from zero.
- R4: A write of 0x55 followed by a write of 0xAA restarts the count from zero, clears the armed state and raises no request. Other cycles or writes of 0x55 may lie between the two writes.
- R5: Further writes of 0x55 after the first leave the sequence armed, so a later 0xAA still completes it.
- R6: While enabled, a write of any value other than 0x55 or 0xAA raises `rst_req` in the next cycle.
- R7: A write of 0xAA while the sequence is not armed raises `rst_req` in the next cycle.
- R8: With `win_en` high, any write while the count is below 3P/4 raises `rst_req`. In the final quarter of the period, key writes are accepted as in R4.
- R9: Each request from one fault is a single-cycle pulse. In the cycle it is high, the count is zero and the armed state is clear.
- R10: While `rate_sel` is 0, the count and the armed state are held clear. Enabling the watchdog therefore starts counting from zero, and a 0x55 written before the disable no longer arms the sequence.
- R11: A write of 0x55 alone does not restart the count, so the timeout still falls P cycles after the last restart.
- R12: A 0xAA that completes the key in the final count cycle of the period (count P−1) takes priority over the timeout: no request is raised and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 3 | Period select; 0 disables the watchdog |
| win_en | input | 1 | Window mode: writes are allowed only in the last quarter of the period |
| wr_en | input | 1 | Write strobe for the service register, one cycle per write |
| wr_data | input | 8 | Write data for the service register |
| rd_data | output | 8 | Read data of the service register; always zero |
| rst_req | output | 1 | Registered reset request pulse |

## Verification
Two events can fall in the same cycle: a key completion and the end of the period. The bench provokes this on purpose. It arms the sequence, then tracks its own model count until it reaches P−1, and only then drives the 0xAA. The check passes if no request appears and the next timeout falls a full period later. The random phase also produces coincidences of a bad write with the timeout, and of an early window write with a valid key byte. Every cycle is judged against a reference model in the bench that applies the requirement rules in its own order.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // log2 of the watchdog period for a nonzero rate select
  function automatic int unsigned period_log2(int unsigned base_log2,
                                              int unsigned step_log2,
                                              int unsigned sel);
    return base_log2 + step_log2 * sel;
  endfunction

  // final count value of a period of 2^plog cycles
  function automatic logic [63:0] last_count(int unsigned plog);
    return (64'd1 << plog) - 64'd1;
  endfunction

  // first count value of the open (final quarter) window
  function automatic logic [63:0] window_start(int unsigned plog);
    return 64'd3 << (plog - 2);
  endfunction

endpackage

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned STEP_LOG2 = 2,
  parameter int unsigned CNT_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              win_en,
  input  logic              clear,
  output logic [CNT_W-1:0]  cnt,
  output logic              enabled,
  output logic              timeout_hit,
  output logic              window_open
);
  import wdog_pkg::*;

  logic [63:0] cnt_wide;
  logic [63:0] last_val;
  logic [63:0] open_val;

  assign enabled  = (rate_sel != '0);
  assign cnt_wide = 64'(cnt);

  always_comb begin
    last_val = last_count(period_log2(BASE_LOG2, STEP_LOG2, int'(rate_sel)));
    open_val = window_start(period_log2(BASE_LOG2, STEP_LOG2, int'(rate_sel)));
  end

  assign timeout_hit = enabled && (cnt_wide >= last_val);
  assign window_open = !win_en || (cnt_wide >= open_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!enabled || clear) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
  parameter int unsigned DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY_ARM  = 8'h55,
  parameter logic [DATA_W-1:0] KEY_FIRE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enabled,
  input  logic              window_open,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fault,
  output logic              armed,
  output logic              key_done,
  output logic              bad_write
);
  logic is_arm;
  logic is_fire;
  logic live_wr;
  logic accepted;

  assign is_arm   = (wr_data == KEY_ARM);
  assign is_fire  = (wr_data == KEY_FIRE);
  assign live_wr  = enabled && wr_en;
  assign accepted = live_wr && window_open;

  assign key_done  = accepted && is_fire && armed;
  assign bad_write = live_wr && (!window_open || !(is_arm || (is_fire && armed)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (!enabled || fault || key_done) begin
      armed <= 1'b0;
    end else if (accepted && is_arm) begin
      armed <= 1'b1;
    end
  end

endmodule

// File: rtl/keyed_window_wdog.sv
module keyed_window_wdog #(
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned STEP_LOG2 = 2,
  parameter int unsigned DATA_W    = 8,
  parameter logic [DATA_W-1:0] KEY_ARM  = 8'h55,
  parameter logic [DATA_W-1:0] KEY_FIRE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              win_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req
);
  localparam int unsigned MAX_SEL = (1 << RATE_W) - 1;
  localparam int unsigned CNT_W   = BASE_LOG2 + STEP_LOG2 * MAX_SEL;

  logic [CNT_W-1:0] cnt_q;
  logic enabled;
  logic timeout_hit;
  logic window_open;
  logic armed;
  logic key_done;
  logic bad_write;
  logic fault;
  logic restart;

  // a completed key in the last count cycle wins over the timeout
  assign fault   = bad_write || (timeout_hit && !key_done);
  assign restart = fault || key_done;
  assign rd_data = '0;

  wdog_tick_counter #(
    .RATE_W(RATE_W), .BASE_LOG2(BASE_LOG2),
    .STEP_LOG2(STEP_LOG2), .CNT_W(CNT_W)
  ) u_ticks (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .win_en(win_en),
    .clear(restart), .cnt(cnt_q), .enabled(enabled),
    .timeout_hit(timeout_hit), .window_open(window_open)
  );

  wdog_key_seq #(
    .DATA_W(DATA_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)
  ) u_keys (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .window_open(window_open),
    .wr_en(wr_en), .wr_data(wr_data), .fault(fault), .armed(armed),
    .key_done(key_done), .bad_write(bad_write)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= fault;
    end
  end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned STEP_LOG2 = 2,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 24,
  parameter logic [DATA_W-1:0] KEY_ARM  = 8'h55,
  parameter logic [DATA_W-1:0] KEY_FIRE = 8'hAA
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RATE_W-1:0] rate_sel,
  input logic              win_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rst_req,
  input logic [CNT_W-1:0]  cnt,
  input logic              armed,
  input logic              key_done,
  input logic              fault,
  input logic              timeout_hit
);
  logic [63:0] per_c;
  logic [63:0] cnt_c;
  logic        on_c;
  logic        early_c;

  always_comb begin
    per_c   = 64'd1 << (BASE_LOG2 + STEP_LOG2 * int'(rate_sel));
    cnt_c   = 64'(cnt);
    on_c    = (rate_sel != '0);
    early_c = (cnt_c * 64'd4) < (per_c * 64'd3);
  end

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !on_c |=> !rst_req);

  p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (on_c && !wr_en && (cnt_c + 64'd1 >= per_c)) |=> rst_req);

  p_key_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> (cnt == '0 && !armed && !rst_req));

  p_arm_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (on_c && wr_en && wr_data == KEY_ARM && !fault) |=> armed);

  p_bad_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (on_c && wr_en && wr_data != KEY_ARM && wr_data != KEY_FIRE) |=> rst_req);

  p_unarmed_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (on_c && wr_en && wr_data == KEY_FIRE && !armed) |=> rst_req);

  p_early_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (on_c && win_en && wr_en && early_c) |=> rst_req);

  p_pulse_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0 && !armed));

  p_idle_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !on_c |=> (cnt == '0 && !armed));

  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (on_c && wr_en && wr_data == KEY_ARM && !fault) |=> (cnt == $past(cnt) + 1'b1));

  p_last_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (key_done && timeout_hit) |=> !rst_req);

endmodule

bind keyed_window_wdog wdog_checker #(
  .RATE_W(RATE_W), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2),
  .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .win_en(win_en),
  .wr_en(wr_en), .wr_data(wr_data), .rst_req(rst_req), .cnt(cnt_q),
  .armed(armed), .key_done(key_done), .fault(fault), .timeout_hit(timeout_hit)
);

// File: tb/keyed_window_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_window_wdog_tb_top;
  localparam int BASE = 4;
  localparam int STEP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       win_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rst_req;

  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  int m_cnt = 0;
  bit m_arm = 0;
  bit m_req = 0;

  always #2.5 clk = ~clk;

  keyed_window_wdog #(.BASE_LOG2(BASE), .STEP_LOG2(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .win_en(win_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req)
  );

  function automatic int per_of(int n);
    return 1 << (BASE + STEP * n);
  endfunction

  function automatic int open_of(int n);
    return per_of(n) - per_of(n) / 4;
  endfunction

  // reference model, rules applied in requirement terms
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || rate_sel == 3'd0) begin
      m_cnt <= 0; m_arm <= 0; m_req <= 0;
    end else begin : step
      bit bad;
      bit ok;
      bad = 0; ok = 0;
      if (wr_en) begin
        if (win_en && m_cnt < open_of(int'(rate_sel))) bad = 1;
        else if (wr_data == 8'h55) ok = 0;
        else if (wr_data == 8'hAA && m_arm) ok = 1;
        else bad = 1;
      end
      if (bad || (!ok && m_cnt >= per_of(int'(rate_sel)) - 1)) begin
        m_req <= 1; m_cnt <= 0; m_arm <= 0;
      end else if (ok) begin
        m_req <= 0; m_cnt <= 0; m_arm <= 0;
      end else begin
        m_req <= 0; m_cnt <= m_cnt + 1;
        if (wr_en && wr_data == 8'h55) m_arm <= 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cur_tag, int'(rst_req), int'(m_req));
      chk("R1", int'(rd_data), 0);
    end
  end

  task automatic wr(logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!rst_req && k < 5000);
  endtask

  task automatic report;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    int k;
    int seed;
    seed = int'($urandom(32'h5eed_0c0b));
    repeat (3) @(negedge clk);
    chk("R1 reset", int'(rst_req), 0);
    chk("R1 reset", int'(rd_data), 0);
    rst_n = 1'b1;

    cur_tag = "R2";
    wr(8'h33); chk("R2", int'(rst_req), 0);
    wr(8'hAA); wr(8'h55);
    gap(300);  chk("R2", int'(rst_req), 0);

    cur_tag = "R3";
    rate_sel = 3'd1;
    measure(k); chk("R3 period n=1", k, per_of(1));
    @(negedge clk); chk("R9 single pulse", int'(rst_req), 0);

    cur_tag = "R4";
    gap(5); wr(8'h55); gap(7); wr(8'hAA);
    chk("R4", int'(rst_req), 0);
    measure(k); chk("R4 restart", k, per_of(1));

    cur_tag = "R5";
    wr(8'h55); wr(8'h55); wr(8'h55); gap(3); wr(8'hAA);
    chk("R5", int'(rst_req), 0);
    measure(k); chk("R5 restart", k, per_of(1));

    cur_tag = "R11";
    gap(10); wr(8'h55);
    measure(k); chk("R11", k, per_of(1) - 11);

    cur_tag = "R6";
    wr(8'h3C); chk("R6", int'(rst_req), 1);
    @(negedge clk); chk("R9", int'(rst_req), 0);

    cur_tag = "R7";
    wr(8'hAA); chk("R7", int'(rst_req), 1);
    gap(1);

    cur_tag = "R12";
    wr(8'h55);
    while (m_cnt != per_of(1) - 1) @(negedge clk);
    wr(8'hAA); chk("R12", int'(rst_req), 0);
    measure(k); chk("R12 restart", k, per_of(1));

    cur_tag = "R8";
    win_en = 1'b1;
    wr(8'h55); chk("R8 early key", int'(rst_req), 1);
    while (m_cnt < open_of(1)) @(negedge clk);
    wr(8'h55); wr(8'hAA); chk("R8 late key", int'(rst_req), 0);
    gap(2); wr(8'hAA); chk("R8 early fire", int'(rst_req), 1);
    win_en = 1'b0;

    cur_tag = "R10";
    gap(2); wr(8'h55);
    rate_sel = 3'd0; gap(3);
    rate_sel = 3'd1; gap(1);
    wr(8'hAA); chk("R10", int'(rst_req), 1);

    cur_tag = "R3";
    rate_sel = 3'd2;
    measure(k); chk("R3 period n=2", k, per_of(2));

    cur_tag = "R3/R4/R6/R8 random";
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom % 1000);
      if (r < 3) rate_sel = 3'($urandom % 3);
      else if (r < 6) win_en = ~win_en;
      if ($urandom % 30 == 0) begin
        int v;
        v = int'($urandom % 10);
        wr_en = 1'b1;
        wr_data = (v < 4) ? 8'h55 : (v < 8) ? 8'hAA : 8'($urandom);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    gap(2);
    report();
  end

endmodule